// File: doc/BRIEF.md
# Static Memory Write Cycle Controller with Frozen Wait

This block runs single write accesses on an asynchronous static-memory bus. A one-cycle start request, given while the block is idle, captures an address, a data word and a set of byte enables. The block then drives an active-low chip select, an active-low write strobe and active-low byte enables for a programmed number of master clock cycles. The setup and pulse lengths of chip select and write strobe, and the total cycle length, arrive as static input ports. Every length is counted in clock cycles.

A slow device can stall the access by pulling an active-low wait input. That input first passes through a two-flop synchronizer. When frozen wait mode is selected, the synchronized wait is acted on only while the pulse selected by the write-mode bit is running. While it is honoured, the cycle counter stops and every bus output keeps its value. When wait is released, the access carries on from the same count. A one-cycle done pulse follows the last counted cycle.

Top module: `sram_wr_ctrl`

## Requirements
- R1: After reset and whenever no access is running, cs_n and we_n are 1, every bit of be_n is 1 and done is 0.
- R2: A start seen while idle captures addr_in, data_in and be_in. For the whole access, addr_out and data_out show the captured values and be_n shows the bitwise inverse of the captured be_in. A start given while an access is running is ignored.
- R3: Let cycle index 0 be the first clock cycle after the edge that accepts start. Absent freezing, the index grows by one per cycle. cs_n is 0 exactly in the cycles whose index lies in [cs_setup, cs_setup+cs_pulse). we_n is 0 exactly in the cycles whose index lies in [we_setup, we_setup+we_pulse).
- R4: done is 1 for exactly one cycle, in the cycle after the cycle of index cycle_len-1. A cycle_len of 0 acts as 1. Absent freezing, done is therefore seen cycle_len cycles after the accepting edge.
- R5: wait_n passes through two flip-flops. A low level on wait_n sampled at clock edge E can freeze the access no earlier than edge E+2.
- R6: With wait_mode equal to 2'b10, each cycle in which the synchronized wait is low inside the window is a frozen cycle. In a frozen cycle the index does not advance, and cs_n, we_n, be_n, addr_out and data_out do not change. Each frozen cycle delays done by one cycle and lengthens whichever strobe is low by one cycle.
- R7: After a freeze the access resumes at the held index and does not restart. The index at which we_n rises is shifted by exactly the number of frozen cycles.
- R8: The window is the set of cycles in which we_n is low when wr_mode is 1, and the set of cycles in which cs_n is low when wr_mode is 0. A synchronized wait outside the window, during setup or hold, is ignored.
- R9: With wait_mode other than 2'b10, wait_n has no effect and the access lasts exactly its programmed length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle access request |
| addr_in | input | AW | Address to capture |
| data_in | input | DW | Write data to capture |
| be_in | input | NB | Byte enables to capture, active high |
| wait_mode | input | 2 | Wait handling; 2'b10 selects frozen mode |
| wr_mode | input | 1 | 1: wait window is the write pulse; 0: the chip-select pulse |
| cs_setup | input | CW | Cycles before cs_n falls |
| cs_pulse | input | CW | Cycles cs_n stays low |
| we_setup | input | CW | Cycles before we_n falls |
| we_pulse | input | CW | Cycles we_n stays low |
| cycle_len | input | CW | Total counted cycles of the access |
| wait_n | input | 1 | Asynchronous wait request from the device, active low |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write strobe, active low |
| addr_out | output | AW | Bus address |
| data_out | output | DW | Bus write data |
| be_n | output | NB | Byte enables, active low |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench sweeps write setup and pulse values and checks where we_n first falls, how long it stays low and when done appears. A decoder with an off-by-one window edge, or a counter that restarts, shows up as a wrong index or a wrong count. Waits of several lengths are placed inside the strobe pulse. A design that only stretches the strobe, or that resumes from zero, gives the wrong we_n rise index or the wrong done latency. Waits placed in setup and in hold, and waits given with the mode off, must leave the timing untouched. One of these waits lands inside the chip-select pulse but before the write pulse, so it must freeze under one wr_mode setting and not under the other. A block that ignores the window, or that picks the wrong strobe for it, fails there. Cycle_len 0, a start given while busy, and the one-cycle width of done are also covered.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
    typedef enum logic [1:0] {
        WM_OFF    = 2'b00,
        WM_RSV_A  = 2'b01,
        WM_FROZEN = 2'b10,
        WM_RSV_B  = 2'b11
    } wait_mode_e;

    localparam int N_STROBES = 2;
    localparam int STB_CS    = 0;
    localparam int STB_WE    = 1;
endpackage

// File: rtl/wait_sync.sv
module wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n,
    output logic wait_s_n
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], wait_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign wait_s_n = sh_q[STAGES-1];

    // R5: a synchronized low appears only after the pin was low two edges earlier
    p_sync_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_s_n) |-> !$past(wait_n, 2));
endmodule

// File: rtl/strobe_window.sv
module strobe_window #(
    parameter int CW = 5
) (
    input  logic          active,
    input  logic [CW-1:0] cyc,
    input  logic [CW-1:0] setup,
    input  logic [CW-1:0] pulse,
    output logic          in_pulse,
    output logic          strobe_n
);
    logic [CW:0] stop_at;
    logic [CW:0] cyc_w;

    always_comb begin
        stop_at  = {1'b0, setup} + {1'b0, pulse};
        cyc_w    = {1'b0, cyc};
        in_pulse = active && (cyc_w >= {1'b0, setup}) && (cyc_w < stop_at);
        strobe_n = !in_pulse;
    end
endmodule

// File: rtl/wr_sequencer.sv
module wr_sequencer
    import sram_wr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int NB = 2,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic [NB-1:0] be_in,
    input  logic [1:0]    wait_mode,
    input  logic          wr_mode,
    input  logic [CW-1:0] cycle_len,
    input  logic          wait_s_n,
    input  logic          cs_win,
    input  logic          we_win,
    output logic          busy,
    output logic [CW-1:0] cyc,
    output logic          freeze,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic [NB-1:0] be_q,
    output logic          done
);
    typedef struct packed {
        logic          active;
        logic [CW-1:0] cyc;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [NB-1:0] be;
        logic          done;
    } seq_t;

    seq_t st_d, st_q;
    logic [CW-1:0] last_idx;
    logic          window;
    logic          hold;

    always_comb begin
        last_idx = (cycle_len == '0) ? '0 : cycle_len - 1'b1;
        window   = wr_mode ? we_win : cs_win;
        hold     = st_q.active && (wait_mode_e'(wait_mode) == WM_FROZEN)
                   && !wait_s_n && window;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.cyc    = '0;
                st_d.addr   = addr_in;
                st_d.data   = data_in;
                st_d.be     = be_in;
            end
        end else if (!hold) begin
            if (st_q.cyc == last_idx) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.cyc = st_q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.active;
    assign cyc    = st_q.cyc;
    assign freeze = hold;
    assign addr_q = st_q.addr;
    assign data_q = st_q.data;
    assign be_q   = st_q.be;
    assign done   = st_q.done;

    // R4: done never lasts two cycles
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: a frozen cycle keeps the access alive at the same index
    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> busy && $stable(cyc));
endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
    import sram_wr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int NB = 2,
    parameter int CW = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic [NB-1:0] be_in,
    input  logic [1:0]    wait_mode,
    input  logic          wr_mode,
    input  logic [CW-1:0] cs_setup,
    input  logic [CW-1:0] cs_pulse,
    input  logic [CW-1:0] we_setup,
    input  logic [CW-1:0] we_pulse,
    input  logic [CW-1:0] cycle_len,
    input  logic          wait_n,
    output logic          cs_n,
    output logic          we_n,
    output logic [AW-1:0] addr_out,
    output logic [DW-1:0] data_out,
    output logic [NB-1:0] be_n,
    output logic          done
);
    logic          wait_s_n;
    logic          busy;
    logic          freeze;
    logic [CW-1:0] cyc;
    logic [NB-1:0] be_q;
    logic [CW-1:0] stb_setup [N_STROBES];
    logic [CW-1:0] stb_pulse [N_STROBES];
    logic [N_STROBES-1:0] stb_win;
    logic [N_STROBES-1:0] stb_n;

    assign stb_setup[STB_CS] = cs_setup;
    assign stb_pulse[STB_CS] = cs_pulse;
    assign stb_setup[STB_WE] = we_setup;
    assign stb_pulse[STB_WE] = we_pulse;

    wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_n   (wait_n),
        .wait_s_n (wait_s_n)
    );

    for (genvar g = 0; g < N_STROBES; g++) begin : g_stb
        strobe_window #(.CW(CW)) u_win (
            .active   (busy),
            .cyc      (cyc),
            .setup    (stb_setup[g]),
            .pulse    (stb_pulse[g]),
            .in_pulse (stb_win[g]),
            .strobe_n (stb_n[g])
        );
    end

    wr_sequencer #(.AW(AW), .DW(DW), .NB(NB), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .addr_in   (addr_in),
        .data_in   (data_in),
        .be_in     (be_in),
        .wait_mode (wait_mode),
        .wr_mode   (wr_mode),
        .cycle_len (cycle_len),
        .wait_s_n  (wait_s_n),
        .cs_win    (stb_win[STB_CS]),
        .we_win    (stb_win[STB_WE]),
        .busy      (busy),
        .cyc       (cyc),
        .freeze    (freeze),
        .addr_q    (addr_out),
        .data_q    (data_out),
        .be_q      (be_q),
        .done      (done)
    );

    assign cs_n = stb_n[STB_CS];
    assign we_n = stb_n[STB_WE];
    assign be_n = busy ? ~be_q : '1;

    // R1: bus strobes idle high outside an access
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n && we_n && (&be_n));
    // R6: every bus output holds across a frozen cycle
    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(cs_n) && $stable(we_n) && $stable(be_n)
                   && $stable(addr_out) && $stable(data_out));
    // R8: a freeze happens only while the selected strobe is low
    p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (wr_mode ? !we_n : !cs_n));
    // R2: captured address does not move during an access
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(addr_out) && $stable(data_out));
endmodule

// File: tb/sim_sram_wr_ctrl.sv
module sim_sram_wr_ctrl;
    localparam int AW = 8, DW = 16, NB = 2, CW = 5;

    logic clk = 0, rst_n = 0, start = 0, wr_mode = 1, wait_n = 1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic [NB-1:0] be_in = '0;
    logic [1:0] wait_mode = 2'b10;
    logic [CW-1:0] cs_setup = 1, cs_pulse = 7, we_setup = 2, we_pulse = 5, cycle_len = 10;
    logic cs_n, we_n, done;
    logic [AW-1:0] addr_out;
    logic [DW-1:0] data_out;
    logic [NB-1:0] be_n;

    int checks = 0, errors = 0;
    bit finished = 0;
    int m_lat, m_cs_cnt, m_we_cnt, m_we_first, m_we_last, m_bad_bus, m_bad_end;

    always #10 clk = ~clk;

    sram_wr_ctrl #(.AW(AW), .DW(DW), .NB(NB), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .data_in(data_in),
        .be_in(be_in), .wait_mode(wait_mode), .wr_mode(wr_mode), .cs_setup(cs_setup),
        .cs_pulse(cs_pulse), .we_setup(we_setup), .we_pulse(we_pulse), .cycle_len(cycle_len),
        .wait_n(wait_n), .cs_n(cs_n), .we_n(we_n), .addr_out(addr_out), .data_out(data_out),
        .be_n(be_n), .done(done));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ws: drive index at which wait_n goes low (-1 = with start), wl: low length
    task automatic run_access(input int ws, input int wl, input bit restart);
        logic [AW-1:0] a = 8'h5A;
        logic [DW-1:0] d = 16'hC3A5;
        logic [NB-1:0] b = 2'b10;
        m_lat = -1; m_cs_cnt = 0; m_we_cnt = 0; m_we_first = -1; m_we_last = -1;
        m_bad_bus = 0; m_bad_end = 0;
        @(negedge clk);
        start = 1; addr_in = a; data_in = d; be_in = b;
        wait_n = (ws <= -1 && -1 < ws + wl) ? 1'b0 : 1'b1;
        for (int idx = 0; idx < 100; idx++) begin
            @(negedge clk);
            start = 0;
            addr_in = 8'hFF; data_in = 16'h0000; be_in = 2'b01;
            if (m_lat >= 0) begin
                if (done || !cs_n || !we_n || be_n != 2'b11) m_bad_end++;
                break;
            end
            if (done) m_lat = idx;
            else begin
                if (!cs_n) m_cs_cnt++;
                if (!we_n) begin
                    m_we_cnt++;
                    if (m_we_first < 0) m_we_first = idx;
                    m_we_last = idx;
                end
                if (addr_out != a || data_out != d || be_n != ~b) m_bad_bus++;
            end
            wait_n = (ws <= idx && idx < ws + wl) ? 1'b0 : 1'b1;
            if (restart && idx == 3) begin
                start = 1; addr_in = 8'h11; data_in = 16'h2222; be_in = 2'b01;
            end
        end
        wait_n = 1;
        start = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n in reset", cs_n, 1);
        chk("R1", "we_n in reset", we_n, 1);
        chk("R1", "be_n in reset", be_n, 3);
        chk("R1", "done in reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "cs_n idle", cs_n, 1);

        // R3 sweep of write timing, no wait
        cs_setup = 0; cs_pulse = 8; cycle_len = 8; wait_mode = 2'b10;
        for (int s = 0; s < 4; s++) begin
            for (int p = 1; p < 5; p++) begin
                we_setup = CW'(s); we_pulse = CW'(p);
                run_access(-5, 0, 0);
                chk("R3", "we first low", m_we_first, s);
                chk("R3", "we low count", m_we_cnt, p);
                chk("R4", "done latency", m_lat, 8);
            end
        end
        chk("R3", "cs low count", m_cs_cnt, 8);
        chk("R2", "bus values", m_bad_bus, 0);
        chk("R1", "idle after done", m_bad_end, 0);

        cs_setup = 1; cs_pulse = 7; we_setup = 2; we_pulse = 5; cycle_len = 10;
        // R6 R7 freeze inside the pulse, both window selections
        for (int m = 0; m < 2; m++) begin
            for (int w = 1; w < 5; w++) begin
                wr_mode = m[0];
                run_access(2, w, 0);
                chk("R6", "latency with freeze", m_lat, 10 + w);
                chk("R6", "we low count", m_we_cnt, 5 + w);
                chk("R6", "cs low count", m_cs_cnt, 7 + w);
                chk("R7", "we last low index", m_we_last, 6 + w);
                chk("R6", "bus held", m_bad_bus, 0);
            end
        end

        // R5 R8 wait in cs-only setup cycle: ignored for wr_mode 1, honoured for 0
        wr_mode = 1;
        run_access(-1, 1, 0);
        chk("R8", "setup wait ignored, wr_mode 1", m_lat, 10);
        wr_mode = 0;
        run_access(-1, 1, 0);
        chk("R5", "sync delay reaches cs pulse, wr_mode 0", m_lat, 11);
        // R8 wait in hold phase ignored in both modes
        for (int m = 0; m < 2; m++) begin
            wr_mode = m[0];
            run_access(6, 2, 0);
            chk("R8", "hold wait ignored", m_lat, 10);
        end
        // R9 wait mode off
        wr_mode = 1; wait_mode = 2'b00;
        run_access(2, 4, 0);
        chk("R9", "mode off latency", m_lat, 10);
        chk("R9", "mode off we count", m_we_cnt, 5);
        wait_mode = 2'b01;
        run_access(2, 4, 0);
        chk("R9", "mode 01 latency", m_lat, 10);
        wait_mode = 2'b10;

        // R2 start while busy ignored
        run_access(-5, 0, 1);
        chk("R2", "busy restart bus", m_bad_bus, 0);
        chk("R2", "busy restart latency", m_lat, 10);
        chk("R4", "done one cycle", m_bad_end, 0);

        // R4 cycle_len 0 behaves as 1
        cycle_len = 0; cs_setup = 0; cs_pulse = 1; we_setup = 0; we_pulse = 1;
        run_access(-5, 0, 0);
        chk("R4", "cycle_len 0 latency", m_lat, 1);
        chk("R4", "cycle_len 0 we count", m_we_cnt, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule